// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit forms the memory address for integer load and store operations in a 64-bit core. The decode stage presents the register specifiers, the register values read for the base and the index, a displacement and a small set of form flags. The unit returns the effective address together with the access width and signedness, a legality verdict and, for forms that update the base, a request to write the address back into the base register.

The address path covers three kinds of base. The first is the base register. The second is a literal zero when the base specifier is 0. The third is the current instruction address, used by the prefixed PC-relative form. The offset is either a sign-extended displacement or the index register value. In 32-bit mode the upper half of the result is cleared. All checks and the adder are combinational, and the result is held for one cycle in a single output register stage that carries a valid bit.

Top module: `lsea_unit`

## Requirements
- R1: When the form is not PC-relative and the base specifier `in_ra` is 0, the base is zero and `in_ra_val` is ignored.
- R2: The address is base plus `in_rb_val` when `in_indexed` is 1. When `in_indexed` is 0, it is base plus the 34-bit `in_disp` sign-extended to 64 bits, with wraparound modulo 2^64.
- R3: An update form (`in_update`=1) with `in_ra`=0 is illegal.
- R4: An update load with `in_ra` equal to `in_rt` is illegal. An update store with the same specifiers is legal.
- R5: A legal update form raises `out_wb_req` with `out_wb_reg` equal to `in_ra`. The value to write back is `out_ea`.
- R6: When `in_prefixed` and `in_pcrel` are both 1, the base is `in_cia`. In that case a nonzero `in_ra` makes the operation illegal. `in_pcrel` has no effect when `in_prefixed` is 0.
- R7: When `in_narrow` is 1, bits 63:32 of `out_ea` are zero and bits 31:0 are the low half of the full sum.
- R8: Size code `in_size` is 0 for byte, 1 for halfword, 2 for word and 3 for doubleword, and it is passed to `out_size`. A sign-extend request is legal only for halfword and word loads. On a byte, on a doubleword or on any store it is illegal. `out_signed` is 1 only for a legal signed request.
- R9: An illegal operation gives `out_illegal`=1 with `out_mem_req`=0 and `out_wb_req`=0. A legal one gives `out_mem_req`=1.
- R10: Outputs appear one clock after the input. `out_valid` equals the previous cycle's `in_valid`. A synchronous active-low reset clears `out_valid`, `out_mem_req` and `out_wb_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_rt | input | 5 | Data register specifier |
| in_ra | input | 5 | Base register specifier |
| in_ra_val | input | 64 | Value read from the base register |
| in_rb_val | input | 64 | Value read from the index register |
| in_disp | input | 34 | Signed displacement |
| in_indexed | input | 1 | Use index register as offset |
| in_update | input | 1 | Write address back to base register |
| in_store | input | 1 | Store (1) or load (0) |
| in_prefixed | input | 1 | Prefixed encoding |
| in_pcrel | input | 1 | PC-relative bit of prefixed form |
| in_size | input | 2 | Access size code |
| in_sign | input | 1 | Sign-extending load requested |
| in_cia | input | 64 | Current instruction address |
| in_narrow | input | 1 | 32-bit address mode |
| out_valid | output | 1 | Result valid |
| out_ea | output | 64 | Effective address (also writeback value) |
| out_size | output | 2 | Access size code |
| out_signed | output | 1 | Sign-extend the loaded value |
| out_store | output | 1 | Access is a store |
| out_illegal | output | 1 | Illegal instruction |
| out_mem_req | output | 1 | Memory access request |
| out_wb_req | output | 1 | Base register writeback request |
| out_wb_reg | output | 5 | Writeback register specifier |

## Verification
The assertions check four properties on every cycle. An illegal result never requests memory or writeback. A writeback never targets register 0. Narrow mode always clears the upper half of the address. The valid bit follows the input by exactly one cycle. Only the bench's directed scenarios can show that the address arithmetic is right: the zero base, sign extension of negative displacements, the PC-relative base and truncation of a carry into bit 32. The same holds for the asymmetry between update loads and update stores when base and data specifiers match.

// File: rtl/lsea_pkg.sv
// Package: shared widths and size codes for the effective address unit.
// Assumes a 64-bit machine with 32 general registers.
package lsea_pkg;
    localparam int XLEN   = 64;
    localparam int REG_AW = 5;
    localparam int DISP_W = 34;
    localparam int SZ_W   = 2;

    typedef enum logic [SZ_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;
endpackage

// File: rtl/lsea_operand_sel.sv
// Module: selects base and offset for the address adder.
// Assumes the caller qualifies pcrel with the prefixed flag.
module lsea_operand_sel #(
    parameter int XLEN   = 64,
    parameter int REG_AW = 5,
    parameter int DISP_W = 34
) (
    input  logic [REG_AW-1:0] ra,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   cia,
    input  logic              indexed,
    input  logic              pc_base,
    output logic [XLEN-1:0]   base,
    output logic [XLEN-1:0]   offset
);
    localparam int EXT_W = XLEN - DISP_W;

    // Base: instruction address, literal zero, or the base register.
    always_comb begin
        if (pc_base)
            base = cia;
        else if (ra == '0)
            base = '0;
        else
            base = ra_val;
    end

    // Offset: index register or sign-extended displacement.
    always_comb begin
        if (indexed)
            offset = rb_val;
        else
            offset = {{EXT_W{disp[DISP_W-1]}}, disp};
    end
endmodule

// File: rtl/lsea_legality.sv
// Module: decides whether a load/store form is legal.
// Assumes register specifiers come straight from the instruction fields.
module lsea_legality #(
    parameter int REG_AW = 5,
    parameter int SZ_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [REG_AW-1:0] rt,
    input  logic [REG_AW-1:0] ra,
    input  logic              update,
    input  logic              store,
    input  logic              pc_base,
    input  logic [SZ_W-1:0]   size,
    input  logic              sign,
    output logic              illegal
);
    import lsea_pkg::*;

    logic upd_bad, pcrel_bad, sign_bad;

    // Update form: no zero base, and a load may not overwrite its own base.
    always_comb upd_bad = update && ((ra == '0) || (!store && (ra == rt)));

    // PC-relative form requires a zero base specifier.
    always_comb pcrel_bad = pc_base && (ra != '0);

    // Sign extension is only defined for halfword and word loads.
    always_comb sign_bad = sign && (store || (size == SZ_BYTE) || (size == SZ_DBL));

    // Combine the individual verdicts.
    always_comb illegal = upd_bad || pcrel_bad || sign_bad;

    assert_upd_ra0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && update && (ra == '0)) |-> illegal);
    assert_upd_store_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && update && store && (ra != '0) && !pc_base && !sign) |-> !illegal);
endmodule

// File: rtl/lsea_addr_gen.sv
// Module: adds base and offset and applies 32-bit truncation in narrow mode.
// Assumes wraparound arithmetic modulo 2^XLEN.
module lsea_addr_gen #(
    parameter int XLEN   = 64,
    parameter int NARROW = 32
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    input  logic            narrow,
    output logic [XLEN-1:0] ea
);
    logic [XLEN-1:0] sum;

    // Full-width sum.
    always_comb sum = base + offset;

    // Zero-extend from the low half when narrow.
    always_comb begin
        if (narrow)
            ea = {{(XLEN-NARROW){1'b0}}, sum[NARROW-1:0]};
        else
            ea = sum;
    end
endmodule

// File: rtl/lsea_unit.sv
// Module: top of the load/store effective address unit. Combinational
// address and legality path followed by one registered output stage.
// Assumes register values are already read for the given specifiers.
module lsea_unit #(
    parameter int XLEN   = lsea_pkg::XLEN,
    parameter int REG_AW = lsea_pkg::REG_AW,
    parameter int DISP_W = lsea_pkg::DISP_W,
    parameter int SZ_W   = lsea_pkg::SZ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [REG_AW-1:0] in_rt,
    input  logic [REG_AW-1:0] in_ra,
    input  logic [XLEN-1:0]   in_ra_val,
    input  logic [XLEN-1:0]   in_rb_val,
    input  logic [DISP_W-1:0] in_disp,
    input  logic              in_indexed,
    input  logic              in_update,
    input  logic              in_store,
    input  logic              in_prefixed,
    input  logic              in_pcrel,
    input  logic [SZ_W-1:0]   in_size,
    input  logic              in_sign,
    input  logic [XLEN-1:0]   in_cia,
    input  logic              in_narrow,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_ea,
    output logic [SZ_W-1:0]   out_size,
    output logic              out_signed,
    output logic              out_store,
    output logic              out_illegal,
    output logic              out_mem_req,
    output logic              out_wb_req,
    output logic [REG_AW-1:0] out_wb_reg
);
    localparam int HALF = XLEN / 2;

    logic            pc_base;
    logic [XLEN-1:0] base, offset, ea;
    logic            illegal;

    // The PC-relative bit only counts in the prefixed encoding.
    always_comb pc_base = in_prefixed && in_pcrel;

    lsea_operand_sel #(.XLEN(XLEN), .REG_AW(REG_AW), .DISP_W(DISP_W)) u_sel (
        .ra(in_ra), .ra_val(in_ra_val), .rb_val(in_rb_val), .disp(in_disp),
        .cia(in_cia), .indexed(in_indexed), .pc_base(pc_base),
        .base(base), .offset(offset)
    );

    lsea_addr_gen #(.XLEN(XLEN), .NARROW(HALF)) u_add (
        .base(base), .offset(offset), .narrow(in_narrow), .ea(ea)
    );

    lsea_legality #(.REG_AW(REG_AW), .SZ_W(SZ_W)) u_legal (
        .clk(clk), .rst_n(rst_n), .valid(in_valid), .rt(in_rt), .ra(in_ra),
        .update(in_update), .store(in_store), .pc_base(pc_base),
        .size(in_size), .sign(in_sign), .illegal(illegal)
    );

    // Control outputs: cleared by reset, qualified by valid and legality.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_mem_req <= 1'b0;
            out_wb_req  <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_mem_req <= in_valid && !illegal;
            out_wb_req  <= in_valid && !illegal && in_update;
        end
    end

    // Data outputs: captured every cycle, meaningful when out_valid is high.
    always_ff @(posedge clk) begin
        out_ea      <= ea;
        out_size    <= in_size;
        out_signed  <= in_sign && !illegal;
        out_store   <= in_store;
        out_illegal <= illegal;
        out_wb_reg  <= in_ra;
    end

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (!out_mem_req && !out_wb_req));
    assert_wb_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_wb_req |-> (out_wb_reg != '0));
    assert_narrow_trunc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_narrow) |=> (out_ea[XLEN-1:HALF] == '0));
    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_signed_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_signed) |-> ((out_size == 2'd1 || out_size == 2'd2) && !out_store));
endmodule

// File: tb/lsea_unit_bench.sv
module lsea_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_rt = '0, in_ra = '0;
    logic [63:0] in_ra_val = '0, in_rb_val = '0, in_cia = '0;
    logic [33:0] in_disp = '0;
    logic        in_indexed = 0, in_update = 0, in_store = 0, in_prefixed = 0, in_pcrel = 0;
    logic [1:0]  in_size = '0;
    logic        in_sign = 0, in_narrow = 0;
    logic        out_valid, out_signed, out_store, out_illegal, out_mem_req, out_wb_req;
    logic [63:0] out_ea;
    logic [1:0]  out_size;
    logic [4:0]  out_wb_reg;

    int checks = 0;
    int errors = 0;
    logic [76:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    lsea_unit u_lsea_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rt(in_rt), .in_ra(in_ra),
        .in_ra_val(in_ra_val), .in_rb_val(in_rb_val), .in_disp(in_disp),
        .in_indexed(in_indexed), .in_update(in_update), .in_store(in_store),
        .in_prefixed(in_prefixed), .in_pcrel(in_pcrel), .in_size(in_size),
        .in_sign(in_sign), .in_cia(in_cia), .in_narrow(in_narrow),
        .out_valid(out_valid), .out_ea(out_ea), .out_size(out_size),
        .out_signed(out_signed), .out_store(out_store), .out_illegal(out_illegal),
        .out_mem_req(out_mem_req), .out_wb_req(out_wb_req), .out_wb_reg(out_wb_reg)
    );

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Driver: apply one operation and push its expected result.
    task automatic drive(input string tag, input logic [4:0] rt, input logic [4:0] ra,
                         input logic [63:0] rav, input logic [63:0] rbv,
                         input logic [33:0] disp, input logic idx, input logic upd,
                         input logic st, input logic pfx, input logic pcr,
                         input logic [1:0] sz, input logic sg, input logic [63:0] cia,
                         input logic nar);
        logic [63:0] base, off, ea;
        logic        pcb, ill;
        @(negedge clk);
        in_valid = 1; in_rt = rt; in_ra = ra; in_ra_val = rav; in_rb_val = rbv;
        in_disp = disp; in_indexed = idx; in_update = upd; in_store = st;
        in_prefixed = pfx; in_pcrel = pcr; in_size = sz; in_sign = sg;
        in_cia = cia; in_narrow = nar;
        pcb  = pfx && pcr;
        base = pcb ? cia : ((ra == 0) ? 64'd0 : rav);
        off  = idx ? rbv : {{30{disp[33]}}, disp};
        ea   = base + off;
        if (nar) ea[63:32] = '0;
        ill = (upd && (ra == 0 || (!st && ra == rt))) || (pcb && ra != 0) ||
              (sg && (st || sz == 2'd0 || sz == 2'd3));
        exp_q.push_back({ea, sz, sg && !ill, st, ill, !ill, upd && !ill, ra});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    // Monitor: compare results against the scoreboard as they appear.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [76:0] act;
            act = {out_ea, out_size, out_signed, out_store, out_illegal,
                   out_mem_req, out_wb_req, out_wb_reg};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected result act=%h exp=none", act);
            end else begin
                logic [76:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s act=%h exp=%h", t, act, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 0 || out_mem_req !== 0 || out_wb_req !== 0) begin
            errors++;
            $display("FAIL R10 reset act=%b%b%b exp=000", out_valid, out_mem_req, out_wb_req);
        end
        @(negedge clk); rst_n = 1;
        // R2: D-form, positive and negative displacement
        drive("R2 pos disp", 3, 4, 64'h1000, 64'h0, 34'h10, 0,0,0,0,0, 2'd2,0, 64'h0, 0);
        drive("R2 neg disp", 3, 4, 64'h1000, 64'h0, 34'h3FFFFFFF0, 0,0,0,0,0, 2'd3,0, 64'h0, 0);
        // R1: base specifier zero ignores register value
        drive("R1 zero base", 3, 0, 64'hDEAD0000, 64'h0, 34'h20, 0,0,0,0,0, 2'd0,0, 64'h0, 0);
        // R2: indexed form with wraparound
        drive("R2 indexed", 5, 6, 64'hFFFFFFFFFFFFFFF0, 64'h20, 34'h7, 1,0,1,0,0, 2'd1,0, 64'h0, 0);
        idle();
        // R10: idle cycle produces nothing (monitor flags stray results)
        idle();
        // R5: legal update load
        drive("R5 update load", 7, 8, 64'h4000, 64'h0, 34'h8, 0,1,0,0,0, 2'd2,0, 64'h0, 0);
        // R3, R9: update with zero base
        drive("R3 R9 update ra0", 7, 0, 64'h0, 64'h100, 34'h0, 1,1,1,0,0, 2'd0,0, 64'h0, 0);
        // R4: update load with ra==rt illegal, store legal
        drive("R4 update load ra=rt", 9, 9, 64'h500, 64'h0, 34'h4, 0,1,0,0,0, 2'd3,0, 64'h0, 0);
        drive("R4 update store ra=rt", 9, 9, 64'h500, 64'h0, 34'h4, 0,1,1,0,0, 2'd3,0, 64'h0, 0);
        // R6: PC-relative base, legal and illegal; pcrel without prefix ignored
        drive("R6 pcrel", 2, 0, 64'h0, 64'h0, 34'h200000000, 0,0,0,1,1, 2'd2,0, 64'h0000_1234_0000_0000, 0);
        drive("R6 pcrel ra nonzero", 2, 1, 64'h99, 64'h0, 34'h40, 0,0,0,1,1, 2'd2,0, 64'h8000, 0);
        drive("R6 pcrel no prefix", 2, 1, 64'h99, 64'h0, 34'h40, 0,0,0,0,1, 2'd2,0, 64'h8000, 0);
        // R7: narrow mode truncation of a carry into bit 32
        drive("R7 narrow", 3, 4, 64'h00000001FFFFFFF0, 64'h0, 34'h20, 0,0,0,0,0, 2'd2,0, 64'h0, 1);
        drive("R7 narrow pcrel", 3, 0, 64'h0, 64'h0, 34'h10, 0,0,0,1,1, 2'd0,0, 64'hAB_FFFF_FFF8, 1);
        // R8: sign extension legality
        drive("R8 signed half", 3, 4, 64'h10, 64'h0, 34'h2, 0,0,0,0,0, 2'd1,1, 64'h0, 0);
        drive("R8 signed byte", 3, 4, 64'h10, 64'h0, 34'h2, 0,0,0,0,0, 2'd0,1, 64'h0, 0);
        drive("R8 signed store", 3, 4, 64'h10, 64'h0, 34'h2, 0,0,1,0,0, 2'd2,1, 64'h0, 0);
        drive("R8 R9 signed dbl", 3, 4, 64'h10, 64'h0, 34'h2, 0,0,0,0,0, 2'd3,1, 64'h0, 0);
        idle();
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 missing results act=%0d exp=0", exp_q.size());
        end
        finish_run();
    end
endmodule